// File: doc/BRIEF.md
# Chained Watchdog Counter Bank

The block is a bank of four 64-bit down-counters behind a simple 32-bit register bus. Each counter has its own control word: an enable bit, a read-only running flag, a mode, a trigger source and a prescaler. A watchdog-select word picks which counters may raise the watchdog reset request.

A counter in one-shot mode loads its programmed reload value when software enables it. It then runs down to zero, emits an end-count pulse and stops. A counter in retrigger mode with the chained trigger source selected does not start on enable alone. It reloads and restarts each time its neighbour below it (counter n-1, with counter 0 taking counter 3) emits an end-count pulse. Software therefore keeps a watchdog alive by re-enabling a zero-valued one-shot neighbour, and never has to stop the watchdog counter itself.

A 64-bit count is read over the 32-bit bus without tearing. Reading the low word also captures the high word of the same instant, and the next high-word read returns that capture.

Top module: `wdt_counter_bank`

## Requirements
- R1: After reset every control word reads 0, the watchdog-select word reads 0, and end_pulse and wdog_rst are low.
- R2: Counter n decodes at byte address n*0x10: +0x0 is control, +0x4 is the low count word and +0x8 is the high count word. The watchdog-select word sits at 0x40 in bits [3:0]. Writing the low or high word sets that half of the reload value. Reading the low word returns the low half of the live count. Read data appears on bus_rdata one cycle after the read strobe.
- R3: A low-word read of counter n captures the high half of the live count at that instant. A later high-word read of counter n returns the captured value even if the live count has moved on.
- R4: Control layout: bit 0 is enable, bit 1 is the running flag, bits [3:2] are the mode, bits [7:4] are the trigger source and bits [15:8] are the prescaler. The other fields read back as written. Writes to bit 1 are ignored.
- R5: Mode codes other than 11 behave as one-shot. When the enable bit of a one-shot counter rises, the counter loads the reload value and runs. After reload*P cycles it gives a one-cycle end pulse, clears its running flag and holds 0 until it is re-enabled. P is the prescaler value.
- R6: Enabling a one-shot counter whose reload value is 0 gives an end pulse in the next cycle, and the running flag stays 0.
- R7: Prescaler values 0 and 1 behave as 2.
- R8: In mode 11 with trigger source 0x5, an enabled counter does not start on enable alone. It loads its reload value on the cycle after counter n-1 (mod 4) pulses end. A new pulse while it is running restarts it from the reload value.
- R9: A counter in mode 11 whose trigger source is not 0x5 ignores its neighbour's end pulse.
- R10: wdog_rst is high for one cycle, the cycle after an end pulse from any counter whose bit is set in watchdog-select. With the select word at 0 it never rises.
- R11: Clearing the enable bit stops a counter, clears its running flag and freezes its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| end_pulse | output | 4 | One-cycle end-count pulse for each counter |
| wdog_rst | output | 1 | Watchdog reset request |

## Verification
The assertions take for granted that each bus access is a single-cycle strobe with known address and data, and that reset lasts at least one clock edge. The checks on the holding register and on the frozen count rely on no access arriving that the decode does not expect. The bench drives every access from a task that raises bus_sel for exactly one cycle, between falling edges. It uses only decoded addresses and keeps the reload values small enough that each countdown finishes inside its measuring window.

// File: rtl/wdtb_pkg.sv
package wdtb_pkg;

    localparam logic [1:0] MODE_RETRIG = 2'b11;
    localparam logic [3:0] TRIG_CHAIN  = 4'h5;

    typedef struct packed {
        logic [7:0] presc;
        logic [3:0] trig;
        logic [1:0] mode;
        logic       en;
    } ctrl_t;

endpackage

// File: rtl/wdtb_counter.sv
module wdtb_counter
    import wdtb_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  ctrl_t            ctrl_wdata,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             prev_end_i,
    output ctrl_t            ctrl_o,
    output logic             active_o,
    output logic [CNT_W-1:0] count_o,
    output logic             end_o
);

    localparam logic [PRE_W-1:0] PRE_MIN = PRE_W'(2);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             active;
        logic [CNT_W-1:0] count;
        logic [PRE_W-1:0] div;
        logic             endp;
    } cnt_state_t;

    cnt_state_t q, d;
    logic             start_os, stop, trig_hit, tick;
    logic [PRE_W-1:0] presc_eff;

    always_comb begin
        d         = q;
        d.endp    = 1'b0;
        presc_eff = (q.ctrl.presc < PRE_MIN) ? PRE_MIN : q.ctrl.presc;
        stop      = ctrl_we && !ctrl_wdata.en;
        start_os  = ctrl_we && ctrl_wdata.en && !q.ctrl.en && (ctrl_wdata.mode != MODE_RETRIG);
        trig_hit  = q.ctrl.en && (q.ctrl.mode == MODE_RETRIG) && (q.ctrl.trig == TRIG_CHAIN) && prev_end_i;
        tick      = q.active && (q.div == presc_eff - PRE_W'(1));

        if (ctrl_we) d.ctrl = ctrl_wdata;

        if (stop) begin
            d.active = 1'b0;
        end else if (start_os || trig_hit) begin
            d.count = reload_i;
            d.div   = '0;
            if (reload_i == '0) begin
                d.active = 1'b0;
                d.endp   = 1'b1;
            end else begin
                d.active = 1'b1;
            end
        end else if (q.active) begin
            if (tick) begin
                d.div   = '0;
                d.count = q.count - CNT_W'(1);
                if (q.count == CNT_W'(1)) begin
                    d.active = 1'b0;
                    d.endp   = 1'b1;
                end
            end else begin
                d.div = q.div + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl_o   = q.ctrl;
    assign active_o = q.active;
    assign count_o  = q.count;
    assign end_o    = q.endp;

    // R11: a disabled counter is never running
    a_r11_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ctrl.en |-> !q.active);

    // R11: count frozen while disabled
    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ctrl.en && !ctrl_we) |=> $stable(q.count));

    // R5: the end pulse leaves the counter stopped
    a_r5_end_stops: assert property (@(posedge clk) disable iff (!rst_n)
        q.endp |-> !q.active);

    // R8: a chained trigger loads the reload value
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && !ctrl_we) |=> (q.count == $past(reload_i)));

endmodule

// File: rtl/wdt_counter_bank.sv
module wdt_counter_bank
    import wdtb_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int BUS_W   = 32,
    parameter int ADDR_W  = 8,
    parameter int PRE_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic [NUM_CNT-1:0] end_pulse,
    output logic               wdog_rst
);

    localparam int                CNT_W     = 2 * BUS_W;
    localparam int                IDX_W     = ADDR_W - 4;
    localparam logic [ADDR_W-1:0] WSEL_ADDR = ADDR_W'(NUM_CNT * 16);

    typedef struct packed {
        logic [NUM_CNT-1:0][CNT_W-1:0] reload;
        logic [NUM_CNT-1:0][BUS_W-1:0] hold;
        logic [BUS_W-1:0]              rdata;
        logic [NUM_CNT-1:0]            wsel;
        logic                          wrst;
    } bank_state_t;

    bank_state_t q, d;

    logic [IDX_W-1:0]   idx;
    logic [3:0]         off;
    logic [NUM_CNT-1:0] hit, ctrl_we, rd_low, end_w, act_w;
    ctrl_t              ctrl_w  [NUM_CNT];
    logic [CNT_W-1:0]   count_w [NUM_CNT];
    ctrl_t              ctrl_wr;

    assign idx     = bus_addr[ADDR_W-1:4];
    assign off     = bus_addr[3:0];
    assign ctrl_wr = ctrl_t'({bus_wdata[15:2], bus_wdata[0]});

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign hit[i]     = bus_sel && (idx == IDX_W'(i));
        assign ctrl_we[i] = hit[i] && bus_wr && (off == 4'h0);
        assign rd_low[i]  = hit[i] && !bus_wr && (off == 4'h4);

        wdtb_counter #(
            .CNT_W (CNT_W),
            .PRE_W (PRE_W)
        ) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_we    (ctrl_we[i]),
            .ctrl_wdata (ctrl_wr),
            .reload_i   (q.reload[i]),
            .prev_end_i (end_w[(i + NUM_CNT - 1) % NUM_CNT]),
            .ctrl_o     (ctrl_w[i]),
            .active_o   (act_w[i]),
            .count_o    (count_w[i]),
            .end_o      (end_w[i])
        );

        // R3: the holding word changes only on a low-word read
        a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_low[i] |=> $stable(q.hold[i]));
    end

    always_comb begin
        d      = q;
        d.wrst = |(end_w & q.wsel);
        if (bus_sel && bus_wr) begin
            if (bus_addr == WSEL_ADDR) d.wsel = bus_wdata[NUM_CNT-1:0];
            for (int i = 0; i < NUM_CNT; i++) begin
                if (hit[i] && off == 4'h4) d.reload[i][BUS_W-1:0]     = bus_wdata;
                if (hit[i] && off == 4'h8) d.reload[i][CNT_W-1:BUS_W] = bus_wdata;
            end
        end else if (bus_sel) begin
            d.rdata = '0;
            if (bus_addr == WSEL_ADDR) d.rdata = BUS_W'(q.wsel);
            for (int i = 0; i < NUM_CNT; i++) begin
                if (hit[i]) begin
                    case (off)
                        4'h0: d.rdata = BUS_W'({ctrl_w[i].presc, ctrl_w[i].trig,
                                                ctrl_w[i].mode, act_w[i], ctrl_w[i].en});
                        4'h4: begin
                            d.rdata   = count_w[i][BUS_W-1:0];
                            d.hold[i] = count_w[i][CNT_W-1:BUS_W];
                        end
                        4'h8:    d.rdata = q.hold[i];
                        default: d.rdata = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;
    assign end_pulse = end_w;
    assign wdog_rst  = q.wrst;

    // R10: a reset request follows an end pulse of a selected counter
    a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
        q.wrst |-> $past(|(end_w & q.wsel)));

    // R10: an empty select word never requests reset
    a_r10_none: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wsel == '0 && $stable(q.wsel)) |=> !q.wrst);

endmodule

// File: tb/wdt_counter_bank_tb.sv
module wdt_counter_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  end_pulse;
    logic        wdog_rst;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    wdt_counter_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .end_pulse (end_pulse),
        .wdog_rst  (wdog_rst)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            summary();
        end
    end

    // all tasks begin and end just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(posedge clk); @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_sel = 0;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wait_end(input int c, input int lim, output int k);
        k = 0;
        while (!end_pulse[c] && k < lim) begin
            @(posedge clk); @(negedge clk);
            k++;
        end
    endtask

    task automatic set_reload(input int c, input logic [63:0] v);
        wr(8'(c * 16 + 4), v[31:0]);
        wr(8'(c * 16 + 8), v[63:32]);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int c = 0; c < 4; c++) begin
            rd(8'(c * 16), v);
            check("R1 ctrl", v, 0);
        end
        rd(8'h40, v);
        check("R1 wsel", v, 0);
        check("R1 end_pulse", end_pulse, 0);
        check("R1 wdog_rst", wdog_rst, 0);
    endtask

    task automatic t_ctrl_fields();
        logic [31:0] v;
        wr(8'h00, 32'h0000_03F6);
        rd(8'h00, v);
        check("R4 fields, running bit ignored", v, 32'h0000_03F4);
        wr(8'h40, 32'h0000_000A);
        rd(8'h40, v);
        check("R2 wsel readback", v, 32'h0000_000A);
        wr(8'h40, 0);
        wr(8'h00, 0);
    endtask

    task automatic t_split_read();
        logic [31:0] v;
        set_reload(3, 64'h0000_0002_0000_0001);
        wr(8'h30, 32'h0000_0201);
        rd(8'h34, v);
        check("R2 live low word", v, 1);
        idle(6);
        rd(8'h38, v);
        check("R3 captured high word", v, 2);
        rd(8'h34, v);
        rd(8'h38, v);
        check("R3 later capture", v, 1);
        wr(8'h30, 0);
    endtask

    task automatic t_oneshot(input int rl, input int pre, input int exp, input string req);
        int k;
        logic [31:0] v;
        set_reload(0, 64'(rl));
        wr(8'h00, 32'(pre << 8) | 32'h1);
        wait_end(0, 1000, k);
        check(req, 64'(k), 64'(exp));
        @(posedge clk); @(negedge clk);
        check({req, " pulse one cycle"}, end_pulse[0], 0);
        rd(8'h00, v);
        check({req, " running cleared"}, v[1], 0);
        idle(8);
        rd(8'h04, v);
        check({req, " count held at 0"}, v, 0);
        wr(8'h00, 0);
    endtask

    task automatic t_zero_reload();
        logic [31:0] v;
        set_reload(0, 0);
        wr(8'h00, 32'h0000_0201);
        check("R6 immediate end", end_pulse[0], 1);
        rd(8'h00, v);
        check("R6 running stays 0", v[1], 0);
        wr(8'h00, 0);
    endtask

    task automatic t_chain();
        int k;
        logic [31:0] v;
        set_reload(0, 0);
        set_reload(1, 3);
        set_reload(2, 7);
        wr(8'h20, 32'h0000_024D);
        wr(8'h40, 32'h0000_0002);
        wr(8'h10, 32'h0000_025D);
        rd(8'h10, v);
        check("R8 no start on enable", v[1], 0);
        wr(8'h00, 32'h0000_0201);
        check("R8 neighbour pulse", end_pulse, 4'b0001);
        wait_end(1, 100, k);
        check("R8 chained end time", 64'(k), 7);
        @(posedge clk); @(negedge clk);
        check("R10 reset after selected end", wdog_rst, 1);
        @(posedge clk); @(negedge clk);
        check("R10 reset one cycle", wdog_rst, 0);
        rd(8'h24, v);
        check("R9 wrong trigger ignored", v, 0);
        wr(8'h00, 0);
        wr(8'h00, 32'h0000_0201);
        idle(4);
        wr(8'h00, 0);
        wr(8'h00, 32'h0000_0201);
        wait_end(1, 100, k);
        check("R8 retrigger restarts", 64'(k), 7);
        wr(8'h00, 0);
        wr(8'h10, 0);
        wr(8'h20, 0);
    endtask

    task automatic t_wsel();
        wr(8'h40, 32'h0000_0002);
        set_reload(0, 0);
        wr(8'h00, 32'h0000_0201);
        @(posedge clk); @(negedge clk);
        check("R10 unselected end", wdog_rst, 0);
        wr(8'h00, 0);
        wr(8'h40, 0);
        wr(8'h00, 32'h0000_0201);
        @(posedge clk); @(negedge clk);
        check("R10 empty select", wdog_rst, 0);
        wr(8'h00, 0);
    endtask

    task automatic t_disable();
        logic [31:0] a, b;
        set_reload(2, 100);
        wr(8'h20, 32'h0000_0201);
        idle(10);
        wr(8'h20, 0);
        rd(8'h24, a);
        idle(10);
        rd(8'h24, b);
        check("R11 frozen", b, a);
        check("R11 stopped before zero", a < 100 && a > 0, 1);
        rd(8'h20, a);
        check("R11 running cleared", a[1], 0);
    endtask

    initial begin
        rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_ctrl_fields();
        t_split_read();
        t_oneshot(5, 3, 15, "R5 one-shot time");
        t_oneshot(4, 0, 8, "R7 prescale floor");
        t_zero_reload();
        t_chain();
        t_wsel();
        t_disable();
        summary();
    end

endmodule